// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that runs a list of up to sixteen prepared transfers with no processor action between them. A host write port loads three write-only stores: a transmit word per entry, a command byte per entry, and a pair of queue pointers naming the first and last entry to run. After a start pulse the controller walks the entries in ascending order. For each entry it drives the chip-select pins from that entry's command byte, shifts the transmit word out most significant bit first, and writes the word it receives into a receive store at the same index. The host reads the receive store through a separate read port.

The serial clock comes from a programmable divider. Its rest level follows a polarity input and its sampling edge follows a phase input. A busy flag covers the whole run and a done flag marks its completion. The controller has four states. ST_IDLE holds the pins at rest. ST_LOAD presents the entry's chip selects and holds the clock at rest for one full serial clock period. ST_SHIFT produces the clock edges. ST_STORE captures the received word and then either moves on to the next entry or ends the run. The transitions are IDLE to LOAD on an accepted start, LOAD to SHIFT after two divider ticks, SHIFT to STORE after the last edge, STORE to LOAD when entries remain, and STORE to IDLE after the end entry.

Top module: `spi_cmd_queue`

## Requirements
- R1: After reset, and whenever `busy` is low, `sck` equals `cpol`, `cs` equals `cs_idle`, and `busy` and `done` are 0 until the first run is accepted.
- R2: A write with `wr_sel`=0 stores `wr_data[DW-1:0]` as the transmit word of entry `wr_addr` and ignores the higher bits. `wr_sel`=1 stores a command, with `wr_data[3:0]` as the chip-select levels and `wr_data[4]` as the no-capture bit, and ignores the higher bits. `wr_sel`=2 sets the start pointer from `wr_data[3:0]` and the end pointer from `wr_data[7:4]`. `wr_sel`=3 has no effect.
- R3: While idle, a start pulse is ignored (busy stays low, sck stays at rest, done unchanged) when `div` is below 2 or the start pointer exceeds the end pointer.
- R4: An accepted start raises `busy` and clears `done` in the next cycle. Entries from the start pointer through the end pointer run in ascending order. `busy` falls and `done` rises in the same cycle after the end entry, and `done` then holds until the next accepted start.
- R5: Each entry shifts DW bits, MSB first. With `cpha`=0, data is sampled on the edge leaving the rest level and changes on the edge returning to it. With `cpha`=1, data changes on the leaving edge and is sampled on the returning edge.
- R6: During shifting, `sck` toggles once every `div` clock cycles, so its period is 2×`div` cycles.
- R7: `cs` carries the entry's command bits [3:0] for the whole transfer. Before the first edge of each entry, `sck` rests for at least one full serial period with those levels already present.
- R8: After each entry, the received word is stored at that entry's index of the receive store unless the entry's no-capture bit (command bit 4) is set, in which case the stored value is unchanged. `rd_data` shows entry `rd_addr` combinationally, and all entries reset to 0.
- R9: Transmit words and command bytes keep their values across runs until they are rewritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 transmit, 1 command, 2 pointers |
| wr_addr | input | 4 | Entry index for transmit and command writes |
| wr_data | input | 16 | Host write data, right-justified |
| start | input | 1 | One-cycle request to run the queue |
| cpol | input | 1 | Serial clock rest level |
| cpha | input | 1 | Serial clock phase select |
| div | input | 8 | Half-period of the serial clock in system cycles |
| cs_idle | input | 4 | Chip-select levels while idle |
| miso | input | 1 | Serial data in |
| rd_addr | input | 4 | Receive store read index |
| rd_data | output | 8 | Receive store word at rd_addr |
| busy | output | 1 | Queue running |
| done | output | 1 | Last run completed |
| sck | output | 1 | Serial clock |
| cs | output | 4 | Chip-select pins |
| mosi | output | 1 | Serial data out |

## Verification
A wrong state or a wrong edge counter shows at the pins within one serial period. A lost or extra edge changes the bit count and shifts every later bit of the stream a monitor collects on the sampling edges. A wrong queue pointer shows up first as a wrong chip-select pattern at the next sampling edge, and at the end of the run as a receive entry that was written or left alone wrongly. A bad divider or a bad phase decode appears at the first pair of clock edges as a wrong interval or as bits taken one position off, and a run that never ends shows as busy never falling.

// File: rtl/spi_q_pkg.sv
package spi_q_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_STORE = 2'd3
    } sq_state_t;

    localparam logic [1:0] SEL_TX  = 2'd0;
    localparam logic [1:0] SEL_CMD = 2'd1;
    localparam logic [1:0] SEL_PTR = 2'd2;
endpackage

// File: rtl/spi_q_regfile.sv
module spi_q_regfile #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_q_divider.sv
module spi_q_divider #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    assign tick = run && (cnt == div - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_q_shifter.sv
module spi_q_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_word,
    input  logic          step,
    input  logic          lead,
    input  logic          first,
    input  logic          cpha,
    input  logic          miso,
    output logic          mosi,
    output logic [DW-1:0] rx_word
);
    logic [DW-1:0] sr;

    assign mosi = sr[DW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            rx_word <= '0;
        end else if (load) begin
            sr      <= load_word;
            rx_word <= '0;
        end else if (step) begin
            if (lead) begin
                if (!cpha)       rx_word <= {rx_word[DW-2:0], miso};
                else if (!first) sr      <= {sr[DW-2:0], 1'b0};
            end else begin
                if (!cpha)       sr      <= {sr[DW-2:0], 1'b0};
                else             rx_word <= {rx_word[DW-2:0], miso};
            end
        end
    end
endmodule

// File: rtl/spi_cmd_queue.sv
module spi_cmd_queue
    import spi_q_pkg::*;
#(
    parameter int DW     = 8,
    parameter int QDEPTH = 16,
    parameter int CSW    = 4,
    parameter int DIVW   = 8,
    parameter int WRW    = 16,
    localparam int AW    = $clog2(QDEPTH),
    localparam int EW    = $clog2(2 * DW),
    localparam int CMDW  = CSW + 1,
    localparam int USEDW = (DW > CMDW) ? ((DW > 2 * AW) ? DW : 2 * AW)
                                       : ((CMDW > 2 * AW) ? CMDW : 2 * AW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [AW-1:0]   wr_addr,
    input  logic [WRW-1:0]  wr_data,
    input  logic            start,
    input  logic            cpol,
    input  logic            cpha,
    input  logic [DIVW-1:0] div,
    input  logic [CSW-1:0]  cs_idle,
    input  logic            miso,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            busy,
    output logic            done,
    output logic            sck,
    output logic [CSW-1:0]  cs,
    output logic            mosi
);
    sq_state_t      state_q, state_d;
    logic [AW-1:0]  ptr_q, sp_q, ep_q;
    logic [EW-1:0]  edge_cnt;
    logic           sck_q, done_q;
    logic           tick, launch, last_edge, at_end, store_we;
    logic [DW-1:0]  tx_word, rx_word;
    logic [CMDW-1:0] cmd_word;

    // Bits of the host word above every field are dropped here.
    generate
        if (WRW > USEDW) begin : g_wr_hi
            logic unused_wr_hi;
            assign unused_wr_hi = ^wr_data[WRW-1:USEDW];
        end
    endgenerate

    spi_q_regfile #(.W(DW), .DEPTH(QDEPTH)) u_tx_mem (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && wr_sel == SEL_TX), .waddr(wr_addr),
        .wdata(wr_data[DW-1:0]), .raddr(ptr_q), .rdata(tx_word)
    );

    spi_q_regfile #(.W(CMDW), .DEPTH(QDEPTH)) u_cmd_mem (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && wr_sel == SEL_CMD), .waddr(wr_addr),
        .wdata(wr_data[CMDW-1:0]), .raddr(ptr_q), .rdata(cmd_word)
    );

    spi_q_regfile #(.W(DW), .DEPTH(QDEPTH)) u_rx_mem (
        .clk(clk), .rst_n(rst_n),
        .we(store_we), .waddr(ptr_q),
        .wdata(rx_word), .raddr(rd_addr), .rdata(rd_data)
    );

    spi_q_divider #(.DIVW(DIVW)) u_div (
        .clk(clk), .rst_n(rst_n),
        .run(state_q == ST_LOAD || state_q == ST_SHIFT),
        .div(div), .tick(tick)
    );

    spi_q_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(state_q == ST_LOAD), .load_word(tx_word),
        .step(state_q == ST_SHIFT && tick),
        .lead(!edge_cnt[0]), .first(edge_cnt == '0),
        .cpha(cpha), .miso(miso), .mosi(mosi), .rx_word(rx_word)
    );

    assign launch    = start && (div >= DIVW'(2)) && (sp_q <= ep_q);
    assign last_edge = (edge_cnt == EW'(2 * DW - 1));
    assign at_end    = (ptr_q == ep_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_LOAD;
            ST_LOAD:  if (tick && edge_cnt[0]) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge) state_d = ST_STORE;
            ST_STORE: state_d = at_end ? ST_IDLE : ST_LOAD;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Queue pointers, edge counter, clock level, completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q     <= '0;
            ep_q     <= '0;
            ptr_q    <= '0;
            edge_cnt <= '0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            if (wr_en && wr_sel == SEL_PTR) begin
                sp_q <= wr_data[AW-1:0];
                ep_q <= wr_data[2*AW-1:AW];
            end
            unique case (state_q)
                ST_IDLE: begin
                    sck_q    <= cpol;
                    edge_cnt <= '0;
                    if (launch) begin
                        ptr_q  <= sp_q;
                        done_q <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    sck_q <= cpol;
                    if (tick) edge_cnt <= edge_cnt[0] ? '0 : edge_cnt + 1'b1;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sck_q    <= ~sck_q;
                        edge_cnt <= last_edge ? '0 : edge_cnt + 1'b1;
                    end
                end
                ST_STORE: begin
                    edge_cnt <= '0;
                    if (at_end) done_q <= 1'b1;
                    else        ptr_q  <= ptr_q + 1'b1;
                end
                default: edge_cnt <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = done_q;
        sck      = (state_q == ST_SHIFT) ? sck_q : cpol;
        cs       = (state_q == ST_IDLE) ? cs_idle : cmd_word[CSW-1:0];
        store_we = (state_q == ST_STORE) && !cmd_word[CSW];
    end
endmodule

// File: rtl/spi_cmd_queue_chk.sv
module spi_cmd_queue_chk
    import spi_q_pkg::*;
#(
    parameter int CSW  = 4,
    parameter int DIVW = 8,
    parameter int AW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            cpol,
    input logic [DIVW-1:0] div,
    input logic [CSW-1:0]  cs_idle,
    input logic            busy,
    input logic            done,
    input logic            sck,
    input logic [CSW-1:0]  cs,
    input logic [AW-1:0]   sp,
    input logic [AW-1:0]   ep,
    input sq_state_t       state,
    input logic            tick
);
    p_idle_sck_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == cpol);

    p_idle_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs == cs_idle);

    p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (div < DIVW'(2) || sp > ep)) |=> !busy);

    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && div >= DIVW'(2) && sp <= ep) |=> (busy && !done));

    p_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    p_edge_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !tick) |=> $stable(sck));

    p_gap_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> sck == cpol);
endmodule

bind spi_cmd_queue spi_cmd_queue_chk #(.CSW(CSW), .DIVW(DIVW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .div(div),
    .cs_idle(cs_idle), .busy(busy), .done(done), .sck(sck), .cs(cs),
    .sp(sp_q), .ep(ep_q), .state(state_q), .tick(tick)
);

// File: tb/spi_cmd_queue_tb.sv
`timescale 1ns/100ps
module spi_cmd_queue_tb;
    localparam int DW = 8, QD = 16, CSW = 4, DIVW = 8, WRW = 16, AW = 4;
    localparam int SBW = QD * DW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, start = 1'b0, cpol = 1'b1, cpha = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [WRW-1:0] wr_data = '0;
    logic [DIVW-1:0] div = 8'd2;
    logic [CSW-1:0] cs_idle = 4'hB;
    logic miso;
    logic [DW-1:0] rd_data;
    logic busy, done, sck, mosi;
    logic [CSW-1:0] cs;

    always #2.5 clk = ~clk;

    assign miso = ~mosi;   // inverted loopback slave

    spi_cmd_queue u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .cpol(cpol),
        .cpha(cpha), .div(div), .cs_idle(cs_idle), .miso(miso),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
        .sck(sck), .cs(cs), .mosi(mosi)
    );

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic [7:0] dv;
        logic [3:0] sp;
        logic [3:0] ep;
        logic       newtx;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 1'b0, 8'd2, 4'd0,  4'd3,  1'b1},
        '{1'b0, 1'b1, 8'd3, 4'd2,  4'd6,  1'b1},
        '{1'b1, 1'b0, 8'd2, 4'd7,  4'd7,  1'b1},
        '{1'b1, 1'b1, 8'd4, 4'd10, 4'd15, 1'b1},
        '{1'b0, 1'b0, 8'd2, 4'd0,  4'd15, 1'b0}
    };

    int errors = 0, checks = 0, cyc = 0;
    logic [DW-1:0]  cur_tx [QD];
    logic [CSW-1:0] cur_cs [QD];
    logic [DW-1:0]  pre_rx [QD];

    function automatic logic [DW-1:0] tx_val(input int i, input int v);
        return DW'(i * 37 + v * 91 + 5);
    endfunction

    function automatic logic nocap(input int i);
        return (i == 5) || (i == 12);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] sel, input int a, input logic [WRW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic read_rx(input int a, output logic [DW-1:0] val);
        rd_addr = AW'(a);
        #0.5;
        val = rd_data;
    endtask

    // Pin monitor: collects bits on sampling edges, checks chip selects per bit
    logic sck_prev = 1'b0, busy_prev = 1'b0;
    int run_cnt = 0, run_edges = 0, last_edge = 0, interval = 0, cs_err = 0;
    logic [SBW-1:0] mon_bits = '0;
    logic [3:0] run_sp = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        sck_prev  <= sck;
        busy_prev <= busy;
        if (busy && !busy_prev) begin
            run_cnt <= 0; run_edges <= 0; interval <= 0;
        end else if (busy && sck != sck_prev) begin
            run_edges <= run_edges + 1;
            last_edge <= cyc;
            if (run_edges == 1) interval <= cyc - last_edge;
            if ((sck_prev == cpol) != cpha) begin
                mon_bits <= {mon_bits[SBW-2:0], mosi};
                run_cnt  <= run_cnt + 1;
                if (cs !== cur_cs[(int'(run_sp) + run_cnt / DW) % QD]) cs_err <= cs_err + 1;
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic expect_reject(input string tag);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(tag, {30'd0, busy, sck}, {30'd0, 1'b0, cpol});
        repeat (3) @(negedge clk);
        chk(tag, {29'd0, busy, done, sck}, {29'd0, 1'b0, 1'b0, cpol});
    endtask

    initial begin
        logic [DW-1:0] rv;
        int k;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy/done", {30'd0, busy, done}, 32'd0);
        chk("R1 reset sck rest", 32'(sck), 32'(cpol));
        chk("R1 reset cs idle", 32'(cs), 32'(cs_idle));
        read_rx(0, rv);
        chk("R8 reset rx entry 0", 32'(rv), 32'd0);

        // Command bytes with junk above bit 4 (R2)
        for (int i = 0; i < QD; i++) begin
            cur_cs[i] = CSW'(i ^ 10);
            host_write(2'd1, i, {11'h5A5, nocap(i), cur_cs[i]});
        end
        for (int i = 0; i < QD; i++) begin
            cur_tx[i] = tx_val(i, 9);
            host_write(2'd0, i, {8'hC3, cur_tx[i]});
        end
        host_write(2'd3, 0, 16'hFFFF);   // R2: unused target has no effect
        host_write(2'd2, 0, 16'h0030);

        // R3: rejected starts
        div = 8'd0; expect_reject("R3 div zero");
        div = 8'd1; expect_reject("R3 div one");
        div = 8'd2; host_write(2'd2, 0, 16'h0049);
        expect_reject("R3 start above end");

        // Table walk
        for (int v = 0; v < 5; v++) begin
            vec_t t;
            int n;
            t = VECS[v];
            @(negedge clk);
            cpol = t.cpol; cpha = t.cpha; div = t.dv;
            if (t.newtx) begin
                for (int i = 0; i < QD; i++) begin
                    cur_tx[i] = tx_val(i, v);
                    host_write(2'd0, i, {8'hC3, cur_tx[i]});
                end
            end
            host_write(2'd2, 0, {8'h00, t.ep, t.sp});
            for (int i = 0; i < QD; i++) read_rx(i, pre_rx[i]);
            run_sp = t.sp;
            k = cs_err;
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            chk("R4 busy after start", {30'd0, busy, done}, {30'd0, 1'b1, 1'b0});
            n = 0;
            while (busy && n < 20000) begin @(negedge clk); n++; end
            chk("R4 run completes", {30'd0, busy, done}, {30'd0, 1'b0, 1'b1});
            chk("R1 sck rest after run", 32'(sck), 32'(cpol));
            chk("R1 cs idle after run", 32'(cs), 32'(cs_idle));
            n = int'(t.ep) - int'(t.sp) + 1;
            chk("R5 bit count", 32'(run_cnt), 32'(n * DW));
            for (int j = 0; j < n; j++)
                chk(t.newtx ? "R5 MSB-first word" : "R5 R9 MSB-first word",
                    32'(mon_bits[(n - 1 - j) * DW +: DW]), 32'(cur_tx[int'(t.sp) + j]));
            chk("R7 cs per bit", 32'(cs_err), 32'(k));
            chk("R6 half period", 32'(interval), 32'(t.dv));
            for (int i = 0; i < QD; i++) begin
                logic [DW-1:0] ex;
                ex = (i >= int'(t.sp) && i <= int'(t.ep) && !nocap(i)) ? ~cur_tx[i] : pre_rx[i];
                read_rx(i, rv);
                chk("R8 R2 rx entry", 32'(rv), 32'(ex));
            end
            repeat (3) @(negedge clk);
            chk("R4 done holds", 32'(done), 32'd1);
        end
        finish_run();
    end
endmodule